// File: doc/BRIEF.md
# SCSI Initiator Phase-Check and Handshake Controller

This block carries out one block move on the initiator side of an asynchronous SCSI information-transfer phase. An instruction sequencer hands it a wanted phase code and a byte count with a one-cycle `start`. Each time the target raises REQ, the block samples the bus phase lines (MSG, C/D, I/O) and compares them with the wanted code. If they agree, it completes one REQ/ACK handshake for one byte. If they disagree, it raises a mismatch interrupt and moves nothing more.

The I/O bit sets the direction of each byte. When I/O is 1, the byte travels from the target into the initiator: it is captured from the bus and handed out on `rx_byte`. When I/O is 0, a byte from the memory side is placed on the bus.

Two phases get special treatment at the end of a move:
- In Message Out, an attention request that is pending is withdrawn during the final handshake.
- In Message In, ACK is left asserted after the last byte. It stays asserted until the sequencer issues `clear_ack`.

In target mode the comparison is skipped. Instead, the block drives the wanted code onto the phase lines for the whole move.

All bus inputs pass through a synchronizer of `SYNC_STAGES` flops before the block uses them.

Top module: `scsi_xfer_ctl`

## Requirements
- R1: After reset, `bus_ack`, `bus_atn`, `done`, `mismatch_irq`, `bus_data_oe`, `bus_phase_oe`, `rx_strobe` and `tx_take` are all 0.
- R2: The phase code is {MSG, C/D, I/O}, with these values: 000 data out, 001 data in, 010 command, 011 status, 100 and 101 reserved, 110 message out, 111 message in. If the sampled phase differs from `phase_cmd` at the first REQ of a move:
  - `mismatch_irq` pulses for one cycle;
  - ACK is never asserted;
  - no byte is moved;
  - `done` does not pulse.
- R3: If the phase changes partway through a move, the bytes already handshaken stay moved. At the REQ whose phase is wrong, `mismatch_irq` pulses, no ACK follows, and the move ends without `done`.
- R4: In a phase with I/O=1, each REQ causes the bus byte to appear on `rx_byte` with a one-cycle `rx_strobe`, and then ACK rises. ACK rises only while REQ is high, and ACK falls only after REQ has fallen.
- R5: In a phase with I/O=0, the next `tx_byte` is driven on `bus_data_out` with `bus_data_oe` high, `tx_take` pulses once, and ACK rises afterwards. The bytes reach the bus in the order they are taken.
- R6: A move of N > 0 bytes with no mismatch completes exactly N handshakes, then pulses `done` exactly once. `done` and `mismatch_irq` are never high together.
- R7: `set_atn` raises `bus_atn`. In a message out move (110), ATN stays high during the ACK of every byte except the last. ATN falls on the same edge as the last byte's ACK rises.
- R8: In a message in move (111), ACK stays high after the final handshake until `clear_ack` is pulsed. While ACK is held this way, `start` is ignored.
- R9: A `start` with a count of 0 pulses `done` with no handshake and no moved byte.
- R10: In target mode, `bus_phase_oe` is 1 and `bus_phase_out` equals `phase_cmd` while the move runs. Bus phase lines that disagree with the wanted code raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a move |
| phase_cmd | input | 3 | Wanted phase code {MSG, C/D, I/O} |
| count_cmd | input | CNT_W | Number of bytes in the move |
| target_cmd | input | 1 | 1 = drive the phase lines instead of comparing them |
| clear_ack | input | 1 | Releases an ACK held after message in |
| set_atn | input | 1 | Raises the attention line |
| done | output | 1 | One-cycle pulse when a move completes |
| mismatch_irq | output | 1 | One-cycle pulse on a phase mismatch |
| bus_req | input | 1 | REQ from the target |
| bus_phase_in | input | 3 | Bus phase lines {MSG, C/D, I/O} |
| bus_data_in | input | DATA_W | Bus data lines as received |
| bus_ack | output | 1 | ACK to the target |
| bus_atn | output | 1 | ATN to the target |
| bus_phase_out | output | 3 | Phase code driven in target mode |
| bus_phase_oe | output | 1 | Enable for `bus_phase_out` |
| bus_data_out | output | DATA_W | Byte driven on send |
| bus_data_oe | output | 1 | Enable for `bus_data_out` |
| tx_byte | input | DATA_W | Next byte to send, from the memory side |
| tx_take | output | 1 | Pulse: `tx_byte` was consumed |
| rx_byte | output | DATA_W | Byte received from the bus |
| rx_strobe | output | 1 | Pulse: `rx_byte` is valid |

## Verification
The hardest case to reach is a phase change partway through a move. The target model has to complete some handshakes cleanly and then present a different phase code just before one particular REQ. The bench drives this case through a bus-side task that takes the index of the byte at which to corrupt the phase. That index is chosen at random for about a quarter of the random moves, and is also set directly in a directed case. The two end-of-move cases also need a cooperating target, because each depends on a specific ordering of signals:
- the ATN fall aligned with the last ACK of a message out move;
- the ACK held after message in.

The target model records ATN at every ACK and checks afterwards that ACK is still high.

// File: rtl/scsi_xfer_pkg.sv
// Shared types for the SCSI initiator transfer controller.
// Assumes the phase code is ordered {MSG, C/D, I/O}; bit 0 gives the direction.
package scsi_xfer_pkg;

    typedef enum logic [2:0] {
        PH_DOUT  = 3'b000,
        PH_DIN   = 3'b001,
        PH_CMD   = 3'b010,
        PH_STAT  = 3'b011,
        PH_RSV_O = 3'b100,
        PH_RSV_I = 3'b101,
        PH_MOUT  = 3'b110,
        PH_MIN   = 3'b111
    } scsi_phase_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_REQ,
        ST_PRESENT,
        ST_ACK_ON
    } xfer_state_e;

endpackage

// File: rtl/phase_gate.sv
// Synchronizes the asynchronous bus inputs (REQ, phase lines, data) into the clock domain.
// Compares the synchronized phase with the wanted code.
// In target mode the comparison is forced true and the wanted code is driven onto the phase lines.
// Assumes the target holds phase and data stable while REQ is high, so the three pipelines stay aligned.
module phase_gate
    import scsi_xfer_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic [2:0]        bus_phase,
    input  logic [DATA_W-1:0] bus_data,
    input  scsi_phase_e       want,
    input  logic              tgt_mode,
    input  logic              busy,
    output logic              req_s,
    output logic [DATA_W-1:0] data_s,
    output logic              match,
    output logic [2:0]        phase_drv,
    output logic              phase_oe
);

    localparam int PW = 1 + 3 + DATA_W;

    logic [PW-1:0] pipe [SYNC_STAGES];
    logic [2:0]    phase_s;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                // first stage: capture the raw bus lines
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[g] <= '0;
                    else        pipe[g] <= {bus_req, bus_phase, bus_data};
                end
            end else begin : g_next
                // later stages: shift toward the consumer
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[g] <= '0;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    // unpack the last stage and decide the phase check
    always_comb begin
        req_s     = pipe[SYNC_STAGES-1][PW-1];
        phase_s   = pipe[SYNC_STAGES-1][PW-2 -: 3];
        data_s    = pipe[SYNC_STAGES-1][DATA_W-1:0];
        match     = tgt_mode || (phase_s == want);
        phase_drv = want;
        phase_oe  = busy && tgt_mode;
    end

endmodule

// File: rtl/req_ack_engine.sv
// Per-byte REQ/ACK handshake sequencer and byte counter for one block move.
// On each synchronized REQ it checks the phase. It then either captures the bus byte (I/O=1)
// or presents the next send byte (I/O=0) before raising ACK.
// ACK is lowered after REQ falls, except after the last message in byte, where ACK is held.
// Assumes the target does not drop REQ before it sees ACK.
module req_ack_engine
    import scsi_xfer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        phase_cmd,
    input  logic [CNT_W-1:0]  count_cmd,
    input  logic              target_cmd,
    input  logic              clear_ack,
    input  logic              req_s,
    input  logic [DATA_W-1:0] data_s,
    input  logic              match,
    input  logic [DATA_W-1:0] tx_byte,
    output scsi_phase_e       want,
    output logic              tgt_mode,
    output logic              busy,
    output logic              ack,
    output logic              atn_drop,
    output logic              done,
    output logic              irq,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_strobe,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              tx_take
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    xfer_state_e      state_q;
    scsi_phase_e      want_q;
    logic             tgt_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ack_q;
    logic             held_q;
    logic             last;

    // the byte now in flight is the final one of the move
    always_comb begin
        last     = (cnt_q == ONE);
        atn_drop = (state_q == ST_PRESENT) && last && (want_q == PH_MOUT);
    end

    // main move sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            want_q    <= PH_DOUT;
            tgt_q     <= 1'b0;
            cnt_q     <= '0;
            ack_q     <= 1'b0;
            held_q    <= 1'b0;
            done      <= 1'b0;
            irq       <= 1'b0;
            rx_byte   <= '0;
            rx_strobe <= 1'b0;
            data_out  <= '0;
            data_oe   <= 1'b0;
            tx_take   <= 1'b0;
        end else begin
            done      <= 1'b0;
            irq       <= 1'b0;
            rx_strobe <= 1'b0;
            tx_take   <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (clear_ack && held_q) begin
                        ack_q  <= 1'b0;
                        held_q <= 1'b0;
                    end else if (start && !held_q) begin
                        want_q <= scsi_phase_e'(phase_cmd);
                        tgt_q  <= target_cmd;
                        if (count_cmd == '0) begin
                            done <= 1'b1;
                        end else begin
                            cnt_q   <= count_cmd;
                            state_q <= ST_WAIT_REQ;
                        end
                    end
                end
                ST_WAIT_REQ: begin
                    if (req_s) begin
                        if (!match) begin
                            irq     <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (want_q[0]) begin
                            rx_byte   <= data_s;
                            rx_strobe <= 1'b1;
                            ack_q     <= 1'b1;
                            state_q   <= ST_ACK_ON;
                        end else begin
                            data_out <= tx_byte;
                            data_oe  <= 1'b1;
                            tx_take  <= 1'b1;
                            state_q  <= ST_PRESENT;
                        end
                    end
                end
                ST_PRESENT: begin
                    ack_q   <= 1'b1;
                    state_q <= ST_ACK_ON;
                end
                ST_ACK_ON: begin
                    if (!req_s) begin
                        data_oe <= 1'b0;
                        if (last) begin
                            done    <= 1'b1;
                            state_q <= ST_IDLE;
                            if (want_q == PH_MIN) held_q <= 1'b1;
                            else                  ack_q  <= 1'b0;
                        end else begin
                            ack_q   <= 1'b0;
                            cnt_q   <= cnt_q - ONE;
                            state_q <= ST_WAIT_REQ;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // export the internal state
    always_comb begin
        want     = want_q;
        tgt_mode = tgt_q;
        busy     = (state_q != ST_IDLE);
        ack      = ack_q;
    end

    // R4
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_q) |-> req_s);

    // R2
    irq_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !ack_q);

    // R6
    done_irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && irq));

    // R6
    cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (cnt_q != '0));

    // R8
    held_only_msgin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ack_q) |-> (want_q == PH_MIN));

endmodule

// File: rtl/atn_ctl.sv
// Attention line holder.
// `set_atn` raises ATN; the engine's final-handshake drop request for message out lowers it.
// A drop wins over a simultaneous set.
// Assumes the drop request arrives on the same edge that raises the final ACK.
module atn_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_atn,
    input  logic atn_drop,
    input  logic ack,
    output logic atn
);

    logic atn_q;

    // hold, set or withdraw attention
    always_ff @(posedge clk) begin
        if (!rst_n)        atn_q <= 1'b0;
        else if (atn_drop) atn_q <= 1'b0;
        else if (set_atn)  atn_q <= 1'b1;
    end

    assign atn = atn_q;

    // R7
    atn_fall_at_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(atn_q) |-> ack);

endmodule

// File: rtl/scsi_xfer_ctl.sv
// Top of the SCSI initiator phase-check and handshake controller.
// Joins the input synchronizer and phase check, the handshake engine and the attention holder.
// Assumes an asynchronous target on the bus side and a sequencer issuing one move at a time.
module scsi_xfer_ctl
    import scsi_xfer_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        phase_cmd,
    input  logic [CNT_W-1:0]  count_cmd,
    input  logic              target_cmd,
    input  logic              clear_ack,
    input  logic              set_atn,
    output logic              done,
    output logic              mismatch_irq,
    input  logic              bus_req,
    input  logic [2:0]        bus_phase_in,
    input  logic [DATA_W-1:0] bus_data_in,
    output logic              bus_ack,
    output logic              bus_atn,
    output logic [2:0]        bus_phase_out,
    output logic              bus_phase_oe,
    output logic [DATA_W-1:0] bus_data_out,
    output logic              bus_data_oe,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              tx_take,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_strobe
);

    scsi_phase_e       want;
    logic              tgt_mode;
    logic              busy;
    logic              req_s;
    logic [DATA_W-1:0] data_s;
    logic              match;
    logic              atn_drop;

    phase_gate #(
        .SYNC_STAGES (SYNC_STAGES),
        .DATA_W      (DATA_W)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_phase (bus_phase_in),
        .bus_data  (bus_data_in),
        .want      (want),
        .tgt_mode  (tgt_mode),
        .busy      (busy),
        .req_s     (req_s),
        .data_s    (data_s),
        .match     (match),
        .phase_drv (bus_phase_out),
        .phase_oe  (bus_phase_oe)
    );

    req_ack_engine #(
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .phase_cmd  (phase_cmd),
        .count_cmd  (count_cmd),
        .target_cmd (target_cmd),
        .clear_ack  (clear_ack),
        .req_s      (req_s),
        .data_s     (data_s),
        .match      (match),
        .tx_byte    (tx_byte),
        .want       (want),
        .tgt_mode   (tgt_mode),
        .busy       (busy),
        .ack        (bus_ack),
        .atn_drop   (atn_drop),
        .done       (done),
        .irq        (mismatch_irq),
        .rx_byte    (rx_byte),
        .rx_strobe  (rx_strobe),
        .data_out   (bus_data_out),
        .data_oe    (bus_data_oe),
        .tx_take    (tx_take)
    );

    atn_ctl u_atn (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_atn  (set_atn),
        .atn_drop (atn_drop),
        .ack      (bus_ack),
        .atn      (bus_atn)
    );

endmodule

// File: tb/sim_scsi_xfer_ctl.sv
// Bench for scsi_xfer_ctl.
// A behavioural target model answers ACK with REQ, runs random and directed moves,
// and checks the results against expectations computed here.
module sim_scsi_xfer_ctl;

    localparam int CNT_W  = 16;
    localparam int DATA_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] phase_cmd = '0;
    logic [CNT_W-1:0] count_cmd = '0;
    logic target_cmd = 1'b0;
    logic clear_ack = 1'b0;
    logic set_atn = 1'b0;
    logic bus_req = 1'b0;
    logic [2:0] bus_phase_in = '0;
    logic [DATA_W-1:0] bus_data_in = '0;
    logic [DATA_W-1:0] tx_byte;
    logic done, mismatch_irq, bus_ack, bus_atn, bus_phase_oe, bus_data_oe, tx_take, rx_strobe;
    logic [2:0] bus_phase_out;
    logic [DATA_W-1:0] bus_data_out, rx_byte;

    int checks = 0;
    int failures = 0;
    int done_n = 0, irq_n = 0, rx_n = 0, tx_idx = 0;
    logic [7:0] rx_log [64];
    logic [7:0] exp_rx [16];
    logic [7:0] got_tx [16];
    logic       atn_at [16];

    always #5 clk = ~clk;

    scsi_xfer_ctl #(.SYNC_STAGES(2), .CNT_W(CNT_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .phase_cmd(phase_cmd),
        .count_cmd(count_cmd), .target_cmd(target_cmd), .clear_ack(clear_ack),
        .set_atn(set_atn), .done(done), .mismatch_irq(mismatch_irq),
        .bus_req(bus_req), .bus_phase_in(bus_phase_in), .bus_data_in(bus_data_in),
        .bus_ack(bus_ack), .bus_atn(bus_atn), .bus_phase_out(bus_phase_out),
        .bus_phase_oe(bus_phase_oe), .bus_data_out(bus_data_out),
        .bus_data_oe(bus_data_oe), .tx_byte(tx_byte), .tx_take(tx_take),
        .rx_byte(rx_byte), .rx_strobe(rx_strobe)
    );

    function automatic logic [7:0] tx_pat(input int idx);
        return 8'(idx * 59 + 17);
    endfunction

    assign tx_byte = tx_pat(tx_idx);

    // event monitors
    always @(posedge clk) begin
        if (done) done_n <= done_n + 1;
        if (mismatch_irq) irq_n <= irq_n + 1;
        if (rx_strobe) begin
            rx_log[rx_n % 64] <= rx_byte;
            rx_n <= rx_n + 1;
        end
        if (tx_take) tx_idx <= tx_idx + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic kick(input logic [2:0] ph, input int n, input bit tm);
        @(negedge clk);
        phase_cmd = ph; count_cmd = CNT_W'(n); target_cmd = tm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Behavioural target: one REQ per byte; the phase is corrupted at byte bad_at.
    task automatic target_side(input logic [2:0] ph, input int n, input int bad_at, output int moved);
        moved = 0;
        for (int i = 0; i < n; i++) begin
            bit saw_irq = 1'b0;
            bit saw_ack = 1'b0;
            bus_phase_in = (i == bad_at) ? (ph ^ 3'b010) : ph;
            bus_data_in  = 8'($urandom);
            exp_rx[i]    = bus_data_in;
            repeat (2) @(negedge clk);
            bus_req = 1'b1;
            for (int t = 0; t < 40; t++) begin
                @(negedge clk);
                if (mismatch_irq) saw_irq = 1'b1;
                if (bus_ack) begin saw_ack = 1'b1; break; end
                if (saw_irq) break;
            end
            if (!saw_ack) begin
                bus_req = 1'b0;
                repeat (4) @(negedge clk);
                return;
            end
            got_tx[i] = bus_data_out;
            atn_at[i] = bus_atn;
            moved++;
            bus_req = 1'b0;
            if (i == n - 1 && ph == 3'b111) return;
            for (int t = 0; t < 40; t++) begin
                @(negedge clk);
                if (!bus_ack) break;
            end
        end
    endtask

    task automatic do_move(input logic [2:0] ph, input int n, input int bad_at, input bit tm);
        int d0, i0, r0, t0, moved, exp_moved;
        bit mism;
        d0 = done_n; i0 = irq_n; r0 = rx_n; t0 = tx_idx;
        if (ph == 3'b110) begin
            @(negedge clk); set_atn = 1'b1;
            @(negedge clk); set_atn = 1'b0;
            @(negedge clk);
            chk(bus_atn == 1'b1, "R7 atn set", int'(bus_atn), 1);
        end
        kick(ph, n, tm);
        if (tm) begin
            @(negedge clk);
            chk(bus_phase_oe && bus_phase_out == ph, "R10 phase drive",
                int'({bus_phase_oe, bus_phase_out}), int'({1'b1, ph}));
        end
        target_side(ph, n, bad_at, moved);
        repeat (8) @(negedge clk);
        mism = (bad_at >= 0) && (bad_at < n) && !tm;
        exp_moved = mism ? bad_at : n;
        chk(moved == exp_moved, mism ? "R3 bytes before mismatch" : "R6 handshake count", moved, exp_moved);
        chk(done_n - d0 == (mism ? 0 : 1), "R6 done pulses", done_n - d0, mism ? 0 : 1);
        chk(irq_n - i0 == (mism ? 1 : 0), mism ? "R2 mismatch irq" : "R10 no irq", irq_n - i0, mism ? 1 : 0);
        if (ph[0]) begin
            chk(rx_n - r0 == exp_moved, "R4 rx strobes", rx_n - r0, exp_moved);
            for (int i = 0; i < exp_moved; i++)
                chk(rx_log[(r0 + i) % 64] == exp_rx[i], "R4 rx byte",
                    int'(rx_log[(r0 + i) % 64]), int'(exp_rx[i]));
        end else begin
            chk(tx_idx - t0 == exp_moved, "R5 tx takes", tx_idx - t0, exp_moved);
            for (int i = 0; i < exp_moved; i++)
                chk(got_tx[i] == tx_pat(t0 + i), "R5 tx byte", int'(got_tx[i]), int'(tx_pat(t0 + i)));
        end
        if (ph == 3'b110 && !mism) begin
            for (int i = 0; i < n; i++)
                chk(atn_at[i] == (i != n - 1), "R7 atn at ack", int'(atn_at[i]), int'(i != n - 1));
        end
        if (ph == 3'b111 && !mism) begin
            chk(bus_ack == 1'b1, "R8 ack held", int'(bus_ack), 1);
            @(negedge clk); clear_ack = 1'b1;
            @(negedge clk); clear_ack = 1'b0;
            @(negedge clk);
            chk(bus_ack == 1'b0, "R8 clear_ack", int'(bus_ack), 0);
        end else begin
            chk(bus_ack == 1'b0, "R4 ack low after move", int'(bus_ack), 0);
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        summary();
    end

    initial begin
        int d0, r0;
        void'($urandom(32'h5C51));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({bus_ack, bus_atn, done, mismatch_irq, bus_data_oe, bus_phase_oe, rx_strobe, tx_take} == '0,
            "R1 reset outputs",
            int'({bus_ack, bus_atn, done, mismatch_irq, bus_data_oe, bus_phase_oe, rx_strobe, tx_take}), 0);

        // directed cases
        do_move(3'b001, 4, -1, 1'b0);   // R4 data in
        do_move(3'b000, 4, -1, 1'b0);   // R5 data out
        do_move(3'b010, 3, 0, 1'b0);    // R2 mismatch at first byte
        do_move(3'b011, 5, 2, 1'b0);    // R3 mismatch partway through
        do_move(3'b110, 3, -1, 1'b0);   // R7 message out
        do_move(3'b111, 2, -1, 1'b0);   // R8 message in
        do_move(3'b000, 3, 1, 1'b1);    // R10 target mode ignores bad phase

        // R9 zero count
        d0 = done_n; r0 = rx_n;
        kick(3'b001, 0, 1'b0);
        repeat (4) @(negedge clk);
        chk(done_n - d0 == 1, "R9 zero count done", done_n - d0, 1);
        chk(bus_ack == 1'b0 && rx_n == r0, "R9 zero count no handshake", int'(bus_ack), 0);

        // R8 start ignored while ACK held
        begin
            int moved;
            kick(3'b111, 1, 1'b0);
            target_side(3'b111, 1, -1, moved);
            repeat (6) @(negedge clk);
            d0 = done_n;
            kick(3'b111, 0, 1'b0);
            repeat (6) @(negedge clk);
            chk(done_n == d0, "R8 start ignored while held", done_n - d0, 0);
            chk(bus_ack == 1'b1, "R8 ack still held", int'(bus_ack), 1);
            @(negedge clk); clear_ack = 1'b1;
            @(negedge clk); clear_ack = 1'b0;
            @(negedge clk);
            chk(bus_ack == 1'b0, "R8 released", int'(bus_ack), 0);
        end

        // random moves
        for (int k = 0; k < 24; k++) begin
            logic [2:0] ph;
            int n, bad;
            ph  = 3'($urandom % 8);
            n   = 1 + int'($urandom % 6);
            bad = ($urandom % 4 == 0) ? int'($urandom % n) : -1;
            do_move(ph, n, bad, 1'b0);
        end

        summary();
    end

endmodule